// File: doc/BRIEF.md
# Compiler-Directed ALU Issue Delay Unit

This unit sits in an in-order issue path that has no hardware operand scoreboard. The compiler places compact delay control words in the instruction stream. Each word carries two dependency hints. The unit decodes them and holds the instruction at the head of the issue queue until the named producer results are usable. Every instruction arrives tagged with an ALU class: vector, transcendental, scalar, or control word. A per-cycle slot signal says whether an issue opportunity exists.

For each of the three executing classes, the unit keeps the age of the last four issues of that class. A hint names a producer by class and by how many issues of that class to count back. The hint is satisfied once that producer's age reaches the required latency. The first hint in a control word always applies to the first non-control instruction after the word. The second hint applies to an instruction chosen by a skip code. A control word never stalls and occupies one issue slot.

Top module: `alu_issue_delay`

## Requirements
- R1: With no hint applied to the head instruction, `issue_en` equals `in_valid & slot_avail`.
- R2: `issue_en` is 0 in every cycle where `in_valid` or `slot_avail` is 0. Field inputs are ignored in such cycles.
- R3: A control word (`in_class` = 3) issues in every cycle where it is valid and a slot exists. It is not recorded as a producer of any class. Classes are 0 = vector, 1 = transcendental, 2 = scalar.
- R4: Dependency codes are as follows. 0 is none. 1..4 are vector dependency 1..4. 5..7 are transcendental dependency 1..3. 8 is FMA-accumulate cycle 1. 9..11 are scalar cycle 1..3. Codes 12..15 act as none.
- R5: The first hint applies to the first non-control instruction after the word. Skip code 0 (same) gives the second hint to that same instruction. Code 1 (next) gives it to the following instruction. Codes 2..5 (skip 1..4) give it to the instruction 1..4 places further on. Skip codes 6 and 7 drop the second hint.
- R6: Vector dependency N holds the target until at least 4 cycles have passed since the issue of the Nth most recent vector instruction. Producers are counted only within their own class.
- R7: Transcendental dependency N holds the target until at least 3 cycles have passed since the issue of the Nth most recent transcendental instruction.
- R8: Scalar cycle N holds the target until N cycles have passed since the most recent scalar issue. FMA-accumulate cycle 1 holds it until 1 cycle has passed since the most recent vector issue.
- R9: When both hints land on one instruction, it issues only when both are satisfied.
- R10: A hint whose producer has not issued since reset is satisfied at once. After reset no hint is pending.
- R11: A second hint of none is ignored. A hint is cleared when its target issues, so later instructions are not held by it.
- R12: A control word that issues while a hint is still pending replaces both pending hints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_class | input | 2 | ALU class of head: 0 vector, 1 transcendental, 2 scalar, 3 control word |
| in_dep_first | input | 4 | Control word: first dependency code |
| in_skip | input | 3 | Control word: skip code |
| in_dep_second | input | 4 | Control word: second dependency code |
| slot_avail | input | 1 | An issue opportunity exists this cycle |
| issue_en | output | 1 | Head instruction issues this cycle |

## Verification
The bench goes after the following corner cases:
- A dependency reaching back further than the producers issued since reset. A design that treated the empty history as "just issued" would stall after reset.
- A skip target several instructions away with idle slots in between. A design that counted cycles instead of instructions would hold the wrong instruction.
- A control word that lands while a skip target is pending. A design that kept the old target would stall an unrelated instruction.
- Same-instruction double hints, reserved dependency and skip codes, and per-class counting with mixed classes between producer and consumer. A design that counted across the whole stream would release vector consumers too early or too late.

// File: rtl/dly_pkg.sv
package dly_pkg;
    localparam int CODE_W   = 4;
    localparam int SKIP_W   = 3;
    localparam int DIST_W   = 3;
    localparam int NUM_HIST = 3;

    typedef enum logic [1:0] {
        CLS_VEC = 2'd0,
        CLS_TRN = 2'd1,
        CLS_SCL = 2'd2,
        CLS_CTL = 2'd3
    } alu_class_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'd0;
    localparam logic [CODE_W-1:0] VEC_FIRST = 4'd1;
    localparam logic [CODE_W-1:0] VEC_LAST  = 4'd4;
    localparam logic [CODE_W-1:0] TRN_FIRST = 4'd5;
    localparam logic [CODE_W-1:0] TRN_LAST  = 4'd7;
    localparam logic [CODE_W-1:0] FMA_CYC1  = 4'd8;
    localparam logic [CODE_W-1:0] SCL_FIRST = 4'd9;
    localparam logic [CODE_W-1:0] SCL_LAST  = 4'd11;
    localparam logic [SKIP_W-1:0] SKIP_MAX  = 3'd5;

    typedef struct packed {
        logic              first_v;
        logic [CODE_W-1:0] first_code;
        logic              second_v;
        logic [CODE_W-1:0] second_code;
        logic [DIST_W-1:0] second_dist;
    } hint_state_t;

    function automatic logic code_is_live(input logic [CODE_W-1:0] c);
        return (c >= VEC_FIRST) && (c <= SCL_LAST);
    endfunction
endpackage

// File: rtl/dly_class_history.sv
module dly_class_history #(
    parameter int DEPTH = 4,
    parameter int AGE_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    output logic [DEPTH-1:0][AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_SAT = '1;
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    typedef struct packed {
        logic [DEPTH-1:0][AGE_W-1:0] age;
    } hist_t;

    hist_t st_d, st_q;

    function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
        return (a == AGE_SAT) ? a : a + AGE_ONE;
    endfunction

    // Newest entry sits at index 0; a saturated age means "long ago or never".
    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.age[0] = AGE_ONE;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.age[i] = bump(st_q.age[i-1]);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.age[i] = bump(st_q.age[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign age_o = st_q.age;
endmodule

// File: rtl/dly_dep_check.sv
module dly_dep_check
    import dly_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int AGE_W   = 3,
    parameter int VEC_LAT = 4,
    parameter int TRN_LAT = 3
) (
    input  logic [CODE_W-1:0]                         code,
    input  logic [NUM_HIST-1:0][DEPTH-1:0][AGE_W-1:0] ages,
    output logic                                      ready
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             live;
    logic [1:0]       cls_sel;
    logic [IDX_W-1:0] idx;
    logic [AGE_W-1:0] need;
    logic [AGE_W-1:0] age_sel;

    always_comb begin
        live    = 1'b0;
        cls_sel = CLS_VEC;
        idx     = '0;
        need    = '0;
        if (code >= VEC_FIRST && code <= VEC_LAST) begin
            live    = 1'b1;
            cls_sel = CLS_VEC;
            idx     = IDX_W'(code - VEC_FIRST);
            need    = AGE_W'(VEC_LAT);
        end else if (code >= TRN_FIRST && code <= TRN_LAST) begin
            live    = 1'b1;
            cls_sel = CLS_TRN;
            idx     = IDX_W'(code - TRN_FIRST);
            need    = AGE_W'(TRN_LAT);
        end else if (code == FMA_CYC1) begin
            live    = 1'b1;
            cls_sel = CLS_VEC;
            need    = AGE_W'(1);
        end else if (code >= SCL_FIRST && code <= SCL_LAST) begin
            live    = 1'b1;
            cls_sel = CLS_SCL;
            need    = AGE_W'(code - SCL_FIRST + 4'd1);
        end
        age_sel = ages[cls_sel][idx];
        ready   = !live || (age_sel >= need);
    end
endmodule

// File: rtl/dly_hint_tracker.sv
module dly_hint_tracker
    import dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_fire,
    input  logic              op_fire,
    input  logic [CODE_W-1:0] ctl_first,
    input  logic [SKIP_W-1:0] ctl_skip,
    input  logic [CODE_W-1:0] ctl_second,
    output logic [CODE_W-1:0] head_first,
    output logic [CODE_W-1:0] head_second
);
    hint_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_fire) begin
            st_d.first_v     = code_is_live(ctl_first);
            st_d.first_code  = ctl_first;
            st_d.second_v    = code_is_live(ctl_second) && (ctl_skip <= SKIP_MAX);
            st_d.second_code = ctl_second;
            st_d.second_dist = DIST_W'(ctl_skip);
        end else if (op_fire) begin
            st_d.first_v = 1'b0;
            if (st_q.second_v) begin
                if (st_q.second_dist == '0) st_d.second_v    = 1'b0;
                else                        st_d.second_dist = st_q.second_dist - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_first  = st_q.first_v ? st_q.first_code : CODE_NONE;
    assign head_second = (st_q.second_v && st_q.second_dist == '0) ? st_q.second_code : CODE_NONE;
endmodule

// File: rtl/alu_issue_delay.sv
module alu_issue_delay
    import dly_pkg::*;
#(
    parameter int HIST_DEPTH = 4,
    parameter int AGE_W      = 3,
    parameter int VEC_LAT    = 4,
    parameter int TRN_LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic [CODE_W-1:0] in_dep_first,
    input  logic [SKIP_W-1:0] in_skip,
    input  logic [CODE_W-1:0] in_dep_second,
    input  logic              slot_avail,
    output logic              issue_en
);
    logic [NUM_HIST-1:0][HIST_DEPTH-1:0][AGE_W-1:0] ages;
    logic [1:0][CODE_W-1:0]                         head_code;
    logic [1:0]                                     rdy;
    logic                                           is_ctl;
    logic                                           ctl_fire;
    logic                                           op_fire;

    assign is_ctl   = (in_class == CLS_CTL);
    assign ctl_fire = in_valid && slot_avail && is_ctl;
    assign op_fire  = in_valid && slot_avail && !is_ctl && (&rdy);
    assign issue_en = ctl_fire || op_fire;

    for (genvar g = 0; g < NUM_HIST; g++) begin : g_hist
        dly_class_history #(
            .DEPTH (HIST_DEPTH),
            .AGE_W (AGE_W)
        ) u_hist (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (op_fire && (in_class == 2'(g))),
            .age_o (ages[g])
        );
    end

    dly_hint_tracker u_hint (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_fire    (ctl_fire),
        .op_fire     (op_fire),
        .ctl_first   (in_dep_first),
        .ctl_skip    (in_skip),
        .ctl_second  (in_dep_second),
        .head_first  (head_code[0]),
        .head_second (head_code[1])
    );

    for (genvar k = 0; k < 2; k++) begin : g_chk
        dly_dep_check #(
            .DEPTH   (HIST_DEPTH),
            .AGE_W   (AGE_W),
            .VEC_LAT (VEC_LAT),
            .TRN_LAT (TRN_LAT)
        ) u_dep (
            .code  (head_code[k]),
            .ages  (ages),
            .ready (rdy[k])
        );
    end
endmodule

// File: rtl/dly_issue_checker.sv
module dly_issue_checker #(
    parameter int VEC_LAT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_class,
    input logic       slot_avail,
    input logic       issue_en,
    input logic [3:0] head_first,
    input logic [3:0] head_second
);
    logic [3:0] vec_gap;
    logic [3:0] scl_gap;
    logic       op_go;

    assign op_go = issue_en && (in_class != 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_gap <= 4'hF;
            scl_gap <= 4'hF;
        end else begin
            if (issue_en && in_class == 2'd0) vec_gap <= 4'd1;
            else if (vec_gap != 4'hF)         vec_gap <= vec_gap + 4'd1;
            if (issue_en && in_class == 2'd2) scl_gap <= 4'd1;
            else if (scl_gap != 4'hF)         scl_gap <= scl_gap + 4'd1;
        end
    end

    a_r3_ctl_never_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_avail && in_class == 2'd3) |-> issue_en);

    a_r2_no_slot_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && slot_avail) |-> !issue_en);

    a_r6_vec_dep1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && (head_first == 4'd1 || head_second == 4'd1)) |-> (vec_gap >= 4'(VEC_LAT)));

    a_r8_scalar_cycle3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && (head_first == 4'd11 || head_second == 4'd11)) |-> (scl_gap >= 4'd3));

    a_r11_first_hint_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && head_first != 4'd0) |=> (head_first == 4'd0));
endmodule

bind alu_issue_delay dly_issue_checker #(.VEC_LAT(VEC_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .slot_avail  (slot_avail),
    .issue_en    (issue_en),
    .head_first  (head_code[0]),
    .head_second (head_code[1])
);

// File: tb/sim_alu_issue_delay.sv
`timescale 1ns/100ps
module sim_alu_issue_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = 2'd0;
    logic [3:0] in_dep_first = 4'd0;
    logic [2:0] in_skip = 3'd0;
    logic [3:0] in_dep_second = 4'd0;
    logic       slot_avail = 1'b0;
    logic       issue_en;

    always #2 clk = ~clk;

    alu_issue_delay u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_class      (in_class),
        .in_dep_first  (in_dep_first),
        .in_skip       (in_skip),
        .in_dep_second (in_dep_second),
        .slot_avail    (slot_avail),
        .issue_en      (issue_en)
    );

    typedef struct { int cls; int d0; int sk; int d1; } ins_t;
    ins_t prog[$];
    int   vq[$], tq[$], sq[$];
    int   now = 0;
    int   p0v = 0, p0c = 0, p1v = 0, p1c = 0, pdist = 0;
    int   ctl_seen = 0;
    int   checks = 0, errors = 0;
    bit   done = 0;

    task automatic op(input int c);
        ins_t e; e.cls = c; e.d0 = 0; e.sk = 0; e.d1 = 0; prog.push_back(e);
    endtask
    task automatic ctl(input int a, input int s, input int b);
        ins_t e; e.cls = 3; e.d0 = a; e.sk = s; e.d1 = b; prog.push_back(e);
    endtask

    function automatic int live(input int c);
        return (c >= 1 && c <= 11) ? 1 : 0;
    endfunction

    function automatic int dep_ok(input int c);
        if (c >= 1 && c <= 4)  return (vq.size() < c) ? 1 : int'(now >= vq[c-1] + 4);
        if (c >= 5 && c <= 7)  return (tq.size() < c - 4) ? 1 : int'(now >= tq[c-5] + 3);
        if (c == 8)            return (vq.size() == 0) ? 1 : int'(now >= vq[0] + 1);
        if (c >= 9 && c <= 11) return (sq.size() == 0) ? 1 : int'(now >= sq[0] + (c - 8));
        return 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: cycle %0d issue_en=%0d expected %0d", req, now, act, exp);
        end
    endtask

    initial begin
        #(20000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int directed_len;
        int pc = 0;
        // R10 producer never issued since reset
        ctl(3, 1, 0); op(0);
        // R6 vector dependency, then R11 clear
        op(0); ctl(1, 1, 0); op(0); op(0);
        // R9 two hints on one instruction, per-class counting
        op(1); op(0); ctl(5, 0, 1); op(0);
        // R5 far skip target
        op(0); op(0); ctl(2, 3, 1); op(0); op(0); op(0); op(0);
        // R8 scalar cycle hints
        op(2); ctl(11, 2, 9); op(0); op(0); op(0);
        // R8 FMA-accumulate chain
        op(0); ctl(8, 1, 8); op(0); op(0);
        // R12 replacement of a pending skip target
        ctl(1, 5, 1); op(0); ctl(4, 1, 2); op(0); op(0); op(0); op(0); op(0); op(0);
        // R4 reserved codes, skip codes 6 and 7
        ctl(12, 1, 15); op(0); op(0); ctl(1, 7, 1); op(0); op(0); op(0);
        directed_len = prog.size();
        for (int i = 0; i < 700; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 4)      op(0);
            else if (r < 6) op(1);
            else if (r < 8) op(2);
            else ctl($urandom_range(0, 15), $urandom_range(0, 7), $urandom_range(0, 15));
        end

        // R10 reset state: nothing pending, an instruction would pass
        @(negedge clk);
        in_valid = 1'b1; in_class = 2'd0; slot_avail = 1'b1;
        #1 check("R10", int'(issue_en), 1);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        while (pc < prog.size()) begin
            int v, s, e, a0, a1;
            string tag;
            ins_t h;
            @(negedge clk);
            if (pc < directed_len) begin
                v = 1; s = 1;
            end else begin
                v = ($urandom_range(0, 9) != 0) ? 1 : 0;
                s = ($urandom_range(0, 4) != 0) ? 1 : 0;
            end
            h = prog[pc];
            in_valid = v[0];
            slot_avail = s[0];
            if (v != 0) begin
                in_class = 2'(h.cls); in_dep_first = 4'(h.d0);
                in_skip = 3'(h.sk); in_dep_second = 4'(h.d1);
            end else begin
                in_class = 2'($urandom_range(0, 3)); in_dep_first = 4'($urandom_range(0, 15));
                in_skip = 3'($urandom_range(0, 7)); in_dep_second = 4'($urandom_range(0, 15));
            end
            #1;
            a0 = p0v ? p0c : 0;
            a1 = (p1v != 0 && pdist == 0) ? p1c : 0;
            if (v == 0 || s == 0) begin
                e = 0; tag = "R2";
            end else if (h.cls == 3) begin
                e = 1;
                if (h.d0 >= 12 || h.d1 >= 12 || h.sk > 5) tag = "R4";
                else if (p1v != 0) tag = "R12";
                else tag = "R3";
            end else begin
                e = dep_ok(a0) & dep_ok(a1);
                if (a0 != 0 && a1 != 0)      tag = "R9";
                else if (a1 != 0)            tag = "R5";
                else if (a0 >= 1 && a0 <= 4) tag = (vq.size() < a0) ? "R10" : "R6";
                else if (a0 >= 5 && a0 <= 7) tag = "R7";
                else if (a0 >= 8)            tag = "R8";
                else                         tag = (ctl_seen != 0) ? "R11" : "R1";
            end
            check(tag, int'(issue_en), e);
            @(posedge clk);
            if (e != 0) begin
                if (h.cls == 3) begin
                    ctl_seen = 1;
                    p0v = live(h.d0); p0c = h.d0;
                    p1v = (live(h.d1) != 0 && h.sk <= 5) ? 1 : 0;
                    p1c = h.d1; pdist = h.sk;
                end else begin
                    if (h.cls == 0) vq.push_front(now);
                    if (h.cls == 1) tq.push_front(now);
                    if (h.cls == 2) sq.push_front(now);
                    p0v = 0;
                    if (p1v != 0) begin
                        if (pdist == 0) p1v = 0;
                        else pdist--;
                    end
                end
                pc++;
            end
            now++;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule